// File: doc/BRIEF.md
# Dual-Clock FIFO with Synchronized Status Flags

This block is a first-in first-out buffer between two unrelated clock domains. A producer pushes words on the write clock and a consumer pops them on the read clock. Each domain has its own full flag, empty flag and occupancy count. Every one of these status outputs is a register in the domain that reads it, so no status output ever changes outside its own clock.

The write pointer and the read pointer are kept in binary and also in reflected-binary (Gray) form. Only the Gray form crosses to the other domain, through a flop chain of `SYNC_STAGES` stages. A flag that depends on the far pointer therefore lags by a fixed number of edges of the receiving clock, and the bench can predict that number exactly. The lag only makes the flags more cautious: full may stay high too long and empty may stay high too long, but a push is never taken into a full buffer and a pop is never taken from an empty one.

An active-high asynchronous clear returns both domains to the empty state at once. The data output is registered and updates only on an accepted pop (normal mode, no look-ahead).

Top module: `dual_clk_fifo`

## Requirements
- R1: While `aclr` is high and after it falls: `wr_empty`=1, `rd_empty`=1, `wr_full`=0, `rd_full`=0, `wr_used`=0, `rd_used`=0 and `rd_data`=0.
- R2: A push sampled at a write-clock edge updates `wr_full` and `wr_empty` at that same edge. That is a latency of one write clock.
- R3: After a push, `wr_used` shows the new count at the second write-clock edge, counted from the edge that sampled the push.
- R4: After a push, `rd_empty` and `rd_full` take the new occupancy into account at the n-th read-clock edge after the second write-clock edge, where n is `SYNC_STAGES`.
- R5: After a push, `rd_used` shows the new count at read-clock edge n+1 after the second write-clock edge.
- R6: A pop sampled at a read-clock edge updates `rd_empty`, `rd_full` and `rd_data` at that edge. `rd_data` returns words in the order they were pushed.
- R7: After a pop, `wr_full` and `wr_empty` take it into account at the n-th write-clock edge that follows the read-clock edge which sampled the pop.
- R8: After a pop, `rd_used` shows the new count at the second read-clock edge. `wr_used` shows it at write-clock edge n+1 that follows the pop's read-clock edge.
- R9: A push while `wr_full`=1 is dropped and does not change any stored word. A pop while `rd_empty`=1 is dropped and leaves `rd_data` and the counts unchanged.
- R10: Neither used count ever exceeds `DEPTH`. Full and empty are never high together in the same domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| aclr | input | 1 | Asynchronous clear of both domains, active high |
| wr_req | input | 1 | Push request, sampled on wr_clk |
| wr_data | input | WIDTH | Word to push |
| wr_full | output | 1 | Write-domain full flag |
| wr_empty | output | 1 | Write-domain empty flag |
| wr_used | output | $clog2(DEPTH)+1 | Write-domain occupancy |
| rd_req | input | 1 | Pop request, sampled on rd_clk |
| rd_data | output | WIDTH | Registered word from the last accepted pop |
| rd_full | output | 1 | Read-domain full flag |
| rd_empty | output | 1 | Read-domain empty flag |
| rd_used | output | $clog2(DEPTH)+1 | Read-domain occupancy |

## Verification
The assertions check on every clock the properties that hold at all times. Each crossing pointer changes at most one bit per edge. Neither count goes past `DEPTH`. Full and empty never appear together. The local pointer never runs ahead of the synchronized far pointer in a way that would mean an overflow or underflow. The exact crossing latencies can only be shown by bench scenarios: one side is held idle while the bench counts the edges of the other clock after a single push or pop. Data ordering, dropped requests at the limits and concurrent traffic with two unrelated clock rates also need those scenarios.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    // Widest pointer the helpers handle; modules cast down to their own width.
    localparam int PTR_MAX_W = 16;

    typedef logic [PTR_MAX_W-1:0] ptr_t;

    // Status of one domain, kept together so it is registered as one unit.
    typedef struct packed {
        logic full;
        logic empty;
    } side_flags_t;

    function automatic ptr_t bin_to_gray(ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray_to_bin(ptr_t g);
        ptr_t b;
        b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
        for (int i = PTR_MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         aclr,
    input  logic [W-1:0] d,
    output logic [W-1:0] early,
    output logic [W-1:0] late
);

    logic [W-1:0] st [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or posedge aclr) begin
                if (aclr) st[i] <= '0;
                else      st[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or posedge aclr) begin
                if (aclr) st[i] <= '0;
                else      st[i] <= st[i-1];
            end
        end
    end

    // The tap one stage short of the end feeds registered flags, so the flags
    // land on the STAGES-th edge; the last tap feeds the count register.
    assign early = st[STAGES-2];
    assign late  = st[STAGES-1];

endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_clk,
    input  logic             aclr,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge rd_clk or posedge aclr) begin
        if (aclr)       rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/dcfifo_wr_side.sv
module dcfifo_wr_side
    import dcfifo_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH),
    localparam int PW         = AW + 1
) (
    input  logic          clk,
    input  logic          aclr,
    input  logic          wr_req,
    input  logic [PW-1:0] peer_gray,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [PW-1:0] launch_gray,
    output logic          full,
    output logic          empty,
    output logic [PW-1:0] used
);

    logic [PW-1:0] bin_q, gray_q, launch_q, bin_nx, used_q;
    logic [PW-1:0] peer_early_g, peer_late_g, peer_early_b, peer_late_b;
    side_flags_t   flags_q;

    dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
        .clk   (clk),
        .aclr  (aclr),
        .d     (peer_gray),
        .early (peer_early_g),
        .late  (peer_late_g)
    );

    always_comb begin
        peer_early_b = PW'(gray_to_bin(ptr_t'(peer_early_g)));
        peer_late_b  = PW'(gray_to_bin(ptr_t'(peer_late_g)));
        wr_en        = wr_req && !flags_q.full;
        bin_nx       = bin_q + PW'(wr_en);
    end

    always_ff @(posedge clk or posedge aclr) begin
        if (aclr) begin
            bin_q         <= '0;
            gray_q        <= '0;
            launch_q      <= '0;
            used_q        <= '0;
            flags_q.full  <= 1'b0;
            flags_q.empty <= 1'b1;
        end else begin
            bin_q         <= bin_nx;
            gray_q        <= PW'(bin_to_gray(ptr_t'(bin_nx)));
            launch_q      <= gray_q;
            used_q        <= bin_q - peer_late_b;
            flags_q.full  <= (bin_nx - peer_early_b) == PW'(DEPTH);
            flags_q.empty <= bin_nx == peer_early_b;
        end
    end

    assign wr_addr     = bin_q[AW-1:0];
    assign launch_gray = launch_q;
    assign full        = flags_q.full;
    assign empty       = flags_q.empty;
    assign used        = used_q;

    // R9: the write pointer never gets more than DEPTH ahead of the read pointer it has seen
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (aclr)
        (bin_q - peer_early_b) <= PW'(DEPTH))
        else $error("write pointer overran the read pointer");

    // R4: the pointer sent across moves by at most one bit per edge
    assert_wr_gray_step_R4: assert property (@(posedge clk) disable iff (aclr)
        $countones(launch_q ^ $past(launch_q)) <= 1)
        else $error("write Gray pointer changed more than one bit");

    assert_wr_flags_excl_R10: assert property (@(posedge clk) disable iff (aclr)
        !(full && empty))
        else $error("write domain full and empty together");

    assert_wr_used_bound_R10: assert property (@(posedge clk) disable iff (aclr)
        used <= PW'(DEPTH))
        else $error("write domain count above depth");

endmodule

// File: rtl/dcfifo_rd_side.sv
module dcfifo_rd_side
    import dcfifo_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH),
    localparam int PW         = AW + 1
) (
    input  logic          clk,
    input  logic          aclr,
    input  logic          rd_req,
    input  logic [PW-1:0] peer_gray,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic [PW-1:0] own_gray,
    output logic          full,
    output logic          empty,
    output logic [PW-1:0] used
);

    logic [PW-1:0] bin_q, gray_q, bin_nx, used_q;
    logic [PW-1:0] peer_early_g, peer_late_g, peer_early_b, peer_late_b;
    side_flags_t   flags_q;

    dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
        .clk   (clk),
        .aclr  (aclr),
        .d     (peer_gray),
        .early (peer_early_g),
        .late  (peer_late_g)
    );

    always_comb begin
        peer_early_b = PW'(gray_to_bin(ptr_t'(peer_early_g)));
        peer_late_b  = PW'(gray_to_bin(ptr_t'(peer_late_g)));
        rd_en        = rd_req && !flags_q.empty;
        bin_nx       = bin_q + PW'(rd_en);
    end

    always_ff @(posedge clk or posedge aclr) begin
        if (aclr) begin
            bin_q         <= '0;
            gray_q        <= '0;
            used_q        <= '0;
            flags_q.full  <= 1'b0;
            flags_q.empty <= 1'b1;
        end else begin
            bin_q         <= bin_nx;
            gray_q        <= PW'(bin_to_gray(ptr_t'(bin_nx)));
            used_q        <= peer_late_b - bin_q;
            flags_q.full  <= (peer_early_b - bin_nx) == PW'(DEPTH);
            flags_q.empty <= peer_early_b == bin_nx;
        end
    end

    assign rd_addr  = bin_q[AW-1:0];
    assign own_gray = gray_q;
    assign full     = flags_q.full;
    assign empty    = flags_q.empty;
    assign used     = used_q;

    // R9: the read pointer never passes the write pointer it has seen
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (aclr)
        (peer_early_b - bin_q) <= PW'(DEPTH))
        else $error("read pointer passed the write pointer");

    // R7: the pointer sent across moves by at most one bit per edge
    assert_rd_gray_step_R7: assert property (@(posedge clk) disable iff (aclr)
        $countones(gray_q ^ $past(gray_q)) <= 1)
        else $error("read Gray pointer changed more than one bit");

    assert_rd_flags_excl_R10: assert property (@(posedge clk) disable iff (aclr)
        !(full && empty))
        else $error("read domain full and empty together");

    assert_rd_used_bound_R10: assert property (@(posedge clk) disable iff (aclr)
        used <= PW'(DEPTH))
        else $error("read domain count above depth");

endmodule

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo #(
    parameter int WIDTH       = 8,
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH),
    localparam int PW         = AW + 1
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             aclr,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_full,
    output logic             wr_empty,
    output logic [PW-1:0]    wr_used,
    input  logic             rd_req,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_full,
    output logic             rd_empty,
    output logic [PW-1:0]    rd_used
);

    logic          push_en, pop_en;
    logic [AW-1:0] push_addr, pop_addr;
    logic [PW-1:0] wgray_x, rgray_x;

    dcfifo_wr_side #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_wr (
        .clk         (wr_clk),
        .aclr        (aclr),
        .wr_req      (wr_req),
        .peer_gray   (rgray_x),
        .wr_en       (push_en),
        .wr_addr     (push_addr),
        .launch_gray (wgray_x),
        .full        (wr_full),
        .empty       (wr_empty),
        .used        (wr_used)
    );

    dcfifo_rd_side #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_rd (
        .clk       (rd_clk),
        .aclr      (aclr),
        .rd_req    (rd_req),
        .peer_gray (wgray_x),
        .rd_en     (pop_en),
        .rd_addr   (pop_addr),
        .own_gray  (rgray_x),
        .full      (rd_full),
        .empty     (rd_empty),
        .used      (rd_used)
    );

    dcfifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .wr_clk  (wr_clk),
        .wr_en   (push_en),
        .wr_addr (push_addr),
        .wr_data (wr_data),
        .rd_clk  (rd_clk),
        .aclr    (aclr),
        .rd_en   (pop_en),
        .rd_addr (pop_addr),
        .rd_data (rd_data)
    );

endmodule

// File: tb/tb_dual_clk_fifo.sv
module tb_dual_clk_fifo;

    localparam int W  = 8;
    localparam int D  = 8;
    localparam int N  = 3;
    localparam int PW = $clog2(D) + 1;

    logic          wr_clk = 1'b0, rd_clk = 1'b0, aclr = 1'b1;
    logic          wr_req = 1'b0, rd_req = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic          wr_full, wr_empty, rd_full, rd_empty;
    logic [PW-1:0] wr_used, rd_used;
    logic [W-1:0]  rd_data;

    int ntests = 0;
    int nfail  = 0;

    dual_clk_fifo #(.WIDTH(W), .DEPTH(D), .SYNC_STAGES(N)) dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .aclr(aclr),
        .wr_req(wr_req), .wr_data(wr_data), .wr_full(wr_full),
        .wr_empty(wr_empty), .wr_used(wr_used),
        .rd_req(rd_req), .rd_data(rd_data), .rd_full(rd_full),
        .rd_empty(rd_empty), .rd_used(rd_used)
    );

    // 50 MHz write clock; 33.3 MHz read clock offset so no edges coincide
    initial forever #10 wr_clk = ~wr_clk;
    initial begin #3; forever #15 rd_clk = ~rd_clk; end

    function automatic logic [W-1:0] pat(int i);
        return W'((i * 29 + 7) & 255);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        ntests++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // push one word into a settled FIFO holding lvl words; count edges on both sides
    task automatic push_timed(input logic [W-1:0] d, input int lvl);
        @(negedge wr_clk); wr_req = 1'b1; wr_data = d;
        @(posedge wr_clk); #1; wr_req = 1'b0;
        chk("R2 wr_full",  int'(wr_full),  int'(lvl + 1 == D));
        chk("R2 wr_empty", int'(wr_empty), 0);
        chk("R3 wr_used early", int'(wr_used), lvl);
        @(posedge wr_clk); #1;
        chk("R3 wr_used", int'(wr_used), lvl + 1);
        for (int k = 1; k <= N + 1; k++) begin
            @(posedge rd_clk); #1;
            if (k < N) begin
                chk("R4 rd_empty held", int'(rd_empty), int'(lvl == 0));
                chk("R4 rd_full held",  int'(rd_full),  0);
            end else if (k == N) begin
                chk("R4 rd_empty", int'(rd_empty), 0);
                chk("R4 rd_full",  int'(rd_full),  int'(lvl + 1 == D));
            end
            chk("R5 rd_used", int'(rd_used), (k <= N) ? lvl : lvl + 1);
        end
    endtask

    // pop one word from a settled FIFO holding lvl words
    task automatic pop_timed(input logic [W-1:0] expd, input int lvl);
        @(negedge rd_clk); rd_req = 1'b1;
        @(posedge rd_clk); #1; rd_req = 1'b0;
        fork
            begin
                chk("R6 rd_data",  int'(rd_data),  int'(expd));
                chk("R6 rd_empty", int'(rd_empty), int'(lvl == 1));
                chk("R6 rd_full",  int'(rd_full),  0);
                chk("R8 rd_used early", int'(rd_used), lvl);
                @(posedge rd_clk); #1;
                chk("R8 rd_used", int'(rd_used), lvl - 1);
            end
            begin
                for (int k = 1; k <= N + 1; k++) begin
                    @(posedge wr_clk); #1;
                    if (k < N) begin
                        chk("R7 wr_full held",  int'(wr_full),  int'(lvl == D));
                        chk("R7 wr_empty held", int'(wr_empty), 0);
                    end else if (k == N) begin
                        chk("R7 wr_full",  int'(wr_full),  0);
                        chk("R7 wr_empty", int'(wr_empty), int'(lvl == 1));
                    end
                    chk("R8 wr_used", int'(wr_used), (k <= N) ? lvl : lvl - 1);
                end
            end
        join
    endtask

    task automatic settle();
        repeat (N + 4) @(posedge wr_clk);
        repeat (N + 4) @(posedge rd_clk);
        #1;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        nfail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R1: clear state, during and after clear
        repeat (3) @(posedge wr_clk);
        #1;
        chk("R1 rd_empty in clear", int'(rd_empty), 1);
        chk("R1 wr_empty in clear", int'(wr_empty), 1);
        @(negedge wr_clk); aclr = 1'b0;
        settle();
        chk("R1 wr_empty", int'(wr_empty), 1);
        chk("R1 rd_empty", int'(rd_empty), 1);
        chk("R1 wr_full",  int'(wr_full),  0);
        chk("R1 rd_full",  int'(rd_full),  0);
        chk("R1 wr_used",  int'(wr_used),  0);
        chk("R1 rd_used",  int'(rd_used),  0);
        chk("R1 rd_data",  int'(rd_data),  0);

        // fill every level with exact latency checks
        for (int i = 0; i < D; i++) push_timed(pat(i), i);

        // R9: pushes into a full FIFO are dropped
        @(negedge wr_clk); wr_req = 1'b1; wr_data = 8'hEE;
        repeat (4) @(negedge wr_clk);
        wr_req = 1'b0;
        settle();
        chk("R9 wr_used at full", int'(wr_used), D);
        chk("R9 rd_used at full", int'(rd_used), D);
        chk("R9 wr_full held",    int'(wr_full), 1);
        chk("R10 rd_full not empty", int'(rd_full && rd_empty), 0);

        // drain every level; data order shows nothing was overwritten (R6, R9)
        for (int i = 0; i < D; i++) pop_timed(pat(i), D - i);

        // R9: pops from an empty FIFO are dropped
        @(negedge rd_clk); rd_req = 1'b1;
        repeat (4) @(negedge rd_clk);
        rd_req = 1'b0;
        settle();
        chk("R9 rd_data kept", int'(rd_data), int'(pat(D - 1)));
        chk("R9 rd_used empty", int'(rd_used), 0);
        chk("R9 wr_used empty", int'(wr_used), 0);
        chk("R9 rd_empty held", int'(rd_empty), 1);

        // concurrent traffic with back-pressure on both sides
        fork
            begin
                int sent = 0;
                while (sent < 40) begin
                    @(negedge wr_clk);
                    if (!wr_full) begin
                        wr_req = 1'b1; wr_data = pat(100 + sent); sent++;
                    end else begin
                        wr_req = 1'b0;
                    end
                end
                @(negedge wr_clk); wr_req = 1'b0;
            end
            begin
                int issued = 0, got = 0;
                logic pend = 1'b0;
                while (got < 40) begin
                    @(negedge rd_clk);
                    if (pend) begin
                        chk("R6 stream order", int'(rd_data), int'(pat(100 + got)));
                        got++;
                    end
                    chk("R10 rd flags", int'(rd_full && rd_empty), 0);
                    if (issued < 40 && !rd_empty) begin
                        rd_req = 1'b1; pend = 1'b1; issued++;
                    end else begin
                        rd_req = 1'b0; pend = 1'b0;
                    end
                end
                rd_req = 1'b0;
            end
        join
        settle();
        chk("R10 wr_used drained", int'(wr_used), 0);
        chk("R10 rd_used drained", int'(rd_used), 0);
        chk("R10 wr_empty drained", int'(wr_empty), 1);

        summary();
    end

endmodule